// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is a single-channel SPI master that moves one 8-bit frame per transfer. A parallel byte goes in on `tx_data_i` and a start pulse launches the frame. The engine drives the select, clock and data pins, samples the serial input, and presents the received byte on `rx_data_o` with a one-clock `done_o` pulse. A static divider input sets the serial clock rate: every half period of SCK lasts `div_i + 1` system clocks.

Six configuration inputs shape each frame: enable, clock rest level (CPOL), clock phase (CPHA), bit order, internal loopback and select-pin polarity. Except for enable, every setting is captured when the frame starts, so a change made during a transfer has no effect until the next one. Clearing enable forces the engine back to its idle state at once. `idle_o` tells software when it is safe to change the settings.

The controller has four states. **ST_IDLE** waits for a start. **ST_LEAD** holds select asserted for half an SCK period. **ST_XFER** produces the sixteen clock edges. **ST_TRAIL** holds select for half a period after the last edge. The transitions are: IDLE→LEAD on a start while enabled; LEAD→XFER on the first half-period tick, which is also clock edge 0; XFER→TRAIL on the tick that makes edge 15; TRAIL→IDLE on the next tick, which also raises done. Any state goes to IDLE when enable is low.

Top module: `spi_master_engine`

## Requirements
- R1: While `cfg_enable` is 0, the engine is held idle: a start is ignored, and a transfer in progress is abandoned by the next clock with `busy_o` low and no `done_o` pulse.
- R2: After reset with all configuration at 0: `idle_o`=1, `busy_o`=0, `done_o`=0, `sck_o`=0 and `sel_o`=1.
- R3: With `cfg_lsb_first`=0, the first bit on `mosi_o` is `tx_data_i[7]`, and the first bit sampled is placed in `rx_data_o[7]`.
- R4: With `cfg_lsb_first`=1, the first bit on `mosi_o` is `tx_data_i[0]`, and the first bit sampled is placed in `rx_data_o[0]`.
- R5: Between transfers `sck_o` rests at `cfg_cpol`. Within a frame, the even-numbered edges (0, 2, …, 14) move the clock away from that level.
- R6: With CPHA 0, data is sampled on the even edges, and `mosi_o` changes only on the odd edges.
- R7: With CPHA 1, `mosi_o` changes on the even edges after the first, and data is sampled on the odd edges. Each frame has exactly 16 SCK edges.
- R8: With `cfg_loopback`=1, the received byte equals the transmitted byte, and `miso_i` is ignored.
- R9: The logical select is active low. `sel_o` equals the logical select XOR `cfg_sel_pol`: when idle it is `!cfg_sel_pol`, and during a frame it is `cfg_sel_pol`.
- R10: Take the clock edge that samples the start as cycle 0. `busy_o` and the select are active after it. `done_o` is high for exactly one clock after edge 17·(`div_i`+1), and `rx_data_o` is valid in that same clock.
- R11: A start pulse while `busy_o` is 1 is ignored: no second frame runs and no extra `done_o` pulse appears.
- R12: Changes to CPOL, CPHA, bit order, loopback or select polarity during a frame do not affect that frame.
- R13: `idle_o` is 1 exactly when no frame is in progress, and it is 1 while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Engine enable; 0 holds it idle |
| cfg_lsb_first | input | 1 | 1 selects LSB-first bit order |
| cfg_cpha | input | 1 | Clock phase |
| cfg_cpol | input | 1 | Clock rest level |
| cfg_loopback | input | 1 | Feed transmit data into the receiver |
| cfg_sel_pol | input | 1 | 1 makes the select pin active high |
| div_i | input | DIV_W | Half-period length minus one, in clocks |
| start_i | input | 1 | Start pulse |
| tx_data_i | input | FRAME_W | Byte to send |
| rx_data_o | output | FRAME_W | Byte received |
| done_o | output | 1 | One-clock frame-complete pulse |
| busy_o | output | 1 | Frame in progress |
| idle_o | output | 1 | Safe to change configuration |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| sel_o | output | 1 | Select pin |

## Verification
The select and `busy_o` respond one clock after the start is sampled, so the bench checks them at the first falling edge after that start. The result is due exactly 17·(`div_i`+1) clocks after the start edge. The bench records a cycle stamp with each expected item in its queue, and the monitor compares the elapsed count when `done_o` appears. On each SCK transition a slave model in the bench captures `mosi_o` and advances `miso_i`. It works from a copy of the settings taken at frame start, so the bit order, the edge direction and the edge count are all judged against the requirements rather than the live inputs.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_TRAIL
    } eng_state_t;

    typedef struct packed {
        logic lsb_first;
        logic cpha;
        logic cpol;
        logic loopback;
        logic sel_pol;
    } eng_cfg_t;
endpackage

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
    parameter int FRAME_W = 8,
    parameter int EW      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] tx_i,
    input  logic               lsb_i,
    input  logic               cpha_i,
    input  logic               loop_i,
    input  logic               edge_i,
    input  logic [EW-1:0]      edge_idx_i,
    input  logic               miso_i,
    output logic               mosi_o,
    output logic [FRAME_W-1:0] rx_o
);
    logic [FRAME_W-1:0] tx_sh, rx_sh, tx_rev, rx_rev;
    logic sample_edge, shift_edge, rx_bit;

    generate
        for (genvar i = 0; i < FRAME_W; i++) begin : g_rev
            assign tx_rev[i] = tx_i[FRAME_W-1-i];
            assign rx_rev[i] = rx_sh[FRAME_W-1-i];
        end
    endgenerate

    assign mosi_o      = tx_sh[FRAME_W-1];
    assign rx_bit      = loop_i ? tx_sh[FRAME_W-1] : miso_i;
    assign sample_edge = edge_i && (edge_idx_i[0] == cpha_i);
    assign shift_edge  = edge_i && (edge_idx_i[0] != cpha_i) && (edge_idx_i != '0);
    assign rx_o        = lsb_i ? rx_rev : rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else if (load_i) begin
            tx_sh <= lsb_i ? tx_rev : tx_i;
            rx_sh <= '0;
        end else begin
            if (sample_edge) rx_sh <= {rx_sh[FRAME_W-2:0], rx_bit};
            if (shift_edge)  tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
    import spi_eng_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic               cfg_lsb_first,
    input  logic               cfg_cpha,
    input  logic               cfg_cpol,
    input  logic               cfg_loopback,
    input  logic               cfg_sel_pol,
    input  logic [DIV_W-1:0]   div_i,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] tx_data_i,
    output logic [FRAME_W-1:0] rx_data_o,
    output logic               done_o,
    output logic               busy_o,
    output logic               idle_o,
    output logic               sck_o,
    output logic               mosi_o,
    input  logic               miso_i,
    output logic               sel_o
);
    localparam int EDGES = 2 * FRAME_W;
    localparam int EW    = $clog2(EDGES);

    eng_state_t         state_q, state_d;
    eng_cfg_t           lat_q;
    logic [EW-1:0]      edge_q;
    logic               sck_q, done_q, tick, edge_stb, load;
    logic [FRAME_W-1:0] rx_q, rx_w;

    assign load     = (state_q == ST_IDLE) && start_i && cfg_enable;
    assign edge_stb = tick && ((state_q == ST_LEAD) || (state_q == ST_XFER));

    spi_eng_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(busy_o), .div_i(div_i), .tick_o(tick)
    );

    spi_eng_shifter #(.FRAME_W(FRAME_W), .EW(EW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_i(load), .tx_i(tx_data_i),
        .lsb_i(load ? cfg_lsb_first : lat_q.lsb_first),
        .cpha_i(lat_q.cpha), .loop_i(lat_q.loopback),
        .edge_i(edge_stb), .edge_idx_i(edge_q), .miso_i(miso_i),
        .mosi_o(mosi_o), .rx_o(rx_w)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_XFER;
            ST_XFER:  if (tick && edge_q == EW'(EDGES - 1)) state_d = ST_TRAIL;
            ST_TRAIL: if (tick) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (!cfg_enable)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q  <= '0;
            edge_q <= '0;
            sck_q  <= 1'b0;
            done_q <= 1'b0;
            rx_q   <= '0;
        end else if (!cfg_enable) begin
            edge_q <= '0;
            sck_q  <= cfg_cpol;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    sck_q <= cfg_cpol;
                    if (start_i) begin
                        lat_q  <= '{lsb_first: cfg_lsb_first, cpha: cfg_cpha,
                                    cpol: cfg_cpol, loopback: cfg_loopback,
                                    sel_pol: cfg_sel_pol};
                        edge_q <= '0;
                    end
                end
                ST_LEAD, ST_XFER: begin
                    if (tick) begin
                        sck_q  <= ~sck_q;
                        edge_q <= edge_q + 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        sck_q  <= lat_q.cpol;
                        done_q <= 1'b1;
                        rx_q   <= rx_w;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign idle_o    = (state_q == ST_IDLE);
    assign done_o    = done_q;
    assign rx_data_o = rx_q;
    assign sck_o     = sck_q;
    assign sel_o     = busy_o ? lat_q.sel_pol : ~cfg_sel_pol;
endmodule

// File: rtl/spi_eng_checker.sv
module spi_eng_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic cfg_cpol,
    input logic cfg_sel_pol,
    input logic sck_o,
    input logic sel_o,
    input logic busy_o,
    input logic idle_o,
    input logic done_o
);
    p_disable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> idle_o && !done_o);

    p_rest_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o && $past(idle_o) && $past(rst_n) |-> sck_o == $past(cfg_cpol));

    p_sel_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> sel_o == !cfg_sel_pol);

    p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) |-> $stable(sel_o));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> idle_o && !busy_o);
endmodule

bind spi_master_engine spi_eng_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
    .cfg_sel_pol(cfg_sel_pol), .sck_o(sck_o), .sel_o(sel_o),
    .busy_o(busy_o), .idle_o(idle_o), .done_o(done_o)
);

// File: tb/test_spi_master_engine.sv
`timescale 1ns/1ps
module test_spi_master_engine;
    localparam int FW = 8;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic cfg_enable = 0, cfg_lsb_first = 0, cfg_cpha = 0, cfg_cpol = 0;
    logic cfg_loopback = 0, cfg_sel_pol = 0, start_i = 0, miso_i;
    logic [DW-1:0] div_i = '0;
    logic [FW-1:0] tx_data_i = '0, rx_data_o;
    logic done_o, busy_o, idle_o, sck_o, mosi_o, sel_o;

    spi_master_engine #(.FRAME_W(FW), .DIV_W(DW)) i_spi_master_engine (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_lsb_first(cfg_lsb_first), .cfg_cpha(cfg_cpha), .cfg_cpol(cfg_cpol),
        .cfg_loopback(cfg_loopback), .cfg_sel_pol(cfg_sel_pol), .div_i(div_i),
        .start_i(start_i), .tx_data_i(tx_data_i), .rx_data_o(rx_data_o),
        .done_o(done_o), .busy_o(busy_o), .idle_o(idle_o), .sck_o(sck_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .sel_o(sel_o)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc++;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] rev(logic [FW-1:0] v);
        for (int i = 0; i < FW; i++) rev[i] = v[FW-1-i];
    endfunction

    // slave model, working from settings copied at frame start
    logic b_lsb = 0, b_cpha = 0, b_cpol = 0;
    logic [FW-1:0] sbyte = '0, cap = '0;
    int ecnt = 0;
    logic [3:0] idx = '0;
    bit dir_err = 0;
    assign miso_i = b_lsb ? sbyte[idx[2:0]] : sbyte[3'd7 - idx[2:0]];

    always @(posedge busy_o) begin
        ecnt = 0; idx = '0; cap = '0; dir_err = 0;
    end

    always @(sck_o) begin
        if (busy_o) begin
            if ((ecnt % 2 == 0) && (sck_o == b_cpol)) dir_err = 1;
            if ((ecnt % 2) == int'(b_cpha)) cap = {cap[FW-2:0], mosi_o};
            else if (ecnt != 0) idx = idx + 1'b1;
            ecnt++;
        end
    end

    typedef struct {
        logic [FW-1:0] rx;
        logic [FW-1:0] cap;
        int            t0;
        int            dv;
        string         rtag;
        string         ptag;
    } exp_t;
    exp_t sb_q[$];

    // monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb_q.size() == 0) begin
                chk(0, "R11", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(rx_data_o == e.rx, e.rtag, "received byte", rx_data_o, e.rx);
                chk(cap == e.cap, e.ptag, "mosi bits seen by slave", cap, e.cap);
                chk(ecnt == 16, "R7", "sck edges per frame", ecnt, 16);
                chk(dir_err == 0, "R5", "leading edge direction", dir_err, 0);
                chk(cyc - e.t0 == 17 * (e.dv + 1), "R10", "done latency",
                    cyc - e.t0, 17 * (e.dv + 1));
                chk(idle_o == 1, "R13", "idle with done", idle_o, 1);
            end
        end
    end

    // driver
    task automatic xfer(logic [FW-1:0] tx, logic [FW-1:0] sb, bit lsb, bit cpha,
                        bit cpol, bit loopb, bit pol, int dv, string rtag,
                        bit extra_start = 0, bit mid_change = 0);
        exp_t e;
        @(negedge clk);
        cfg_lsb_first = lsb; cfg_cpha = cpha; cfg_cpol = cpol;
        cfg_loopback = loopb; cfg_sel_pol = pol; div_i = DW'(dv);
        b_lsb = lsb; b_cpha = cpha; b_cpol = cpol; sbyte = sb; tx_data_i = tx;
        @(negedge clk);
        chk(sck_o == cpol, "R5", "rest level before frame", sck_o, cpol);
        chk(sel_o == !pol, "R9", "idle select level", sel_o, !pol);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        e.rx = loopb ? tx : sb;
        e.cap = lsb ? rev(tx) : tx;
        e.t0 = cyc; e.dv = dv; e.rtag = rtag;
        e.ptag = cpha ? "R7" : "R6";
        sb_q.push_back(e);
        chk(busy_o == 1, "R10", "busy after start", busy_o, 1);
        chk(idle_o == 0, "R13", "idle during frame", idle_o, 0);
        chk(sel_o == pol, "R9", "active select level", sel_o, pol);
        if (extra_start) begin
            repeat (5) @(negedge clk);
            tx_data_i = ~tx; start_i = 1;
            @(negedge clk);
            start_i = 0;
        end
        if (mid_change) begin
            repeat (3) @(negedge clk);
            cfg_lsb_first = !lsb; cfg_cpha = !cpha; cfg_cpol = !cpol;
            cfg_loopback = !loopb; cfg_sel_pol = !pol;
            repeat (2) @(negedge clk);
            chk(sel_o == pol, "R12", "select unaffected by change", sel_o, pol);
        end
        while (busy_o) @(negedge clk);
        if (mid_change) begin
            cfg_lsb_first = lsb; cfg_cpha = cpha; cfg_cpol = cpol;
            cfg_loopback = loopb; cfg_sel_pol = pol;
        end
        repeat (2) @(negedge clk);
        chk(sck_o == cpol, "R5", "rest level after frame", sck_o, cpol);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(idle_o == 1, "R2", "idle after reset", idle_o, 1);
        chk(busy_o == 0, "R2", "busy after reset", busy_o, 0);
        chk(done_o == 0, "R2", "done after reset", done_o, 0);
        chk(sck_o == 0, "R2", "sck after reset", sck_o, 0);
        chk(sel_o == 1, "R2", "sel after reset", sel_o, 1);

        // R1: start while disabled is ignored
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        @(negedge clk);
        chk(busy_o == 0, "R1", "start while disabled", busy_o, 0);
        cfg_enable = 1;

        xfer(8'hA5, 8'h3C, 0, 0, 0, 0, 0, 1, "R3");
        xfer(8'h1E, 8'h81, 1, 0, 0, 0, 0, 0, "R4");
        xfer(8'h96, 8'h6B, 0, 0, 1, 0, 0, 2, "R3");
        xfer(8'h4D, 8'hE2, 0, 1, 0, 0, 0, 1, "R3");
        xfer(8'h27, 8'hB4, 1, 1, 1, 0, 0, 3, "R4");
        xfer(8'hC3, 8'h5A, 0, 0, 0, 1, 0, 1, "R8");
        xfer(8'h39, 8'h00, 1, 1, 0, 1, 1, 0, "R8");
        xfer(8'h71, 8'hD8, 0, 0, 0, 0, 1, 2, "R9");
        xfer(8'h5C, 8'h93, 0, 1, 0, 0, 0, 1, "R11", 1, 0);
        xfer(8'hE6, 8'h2F, 1, 0, 1, 0, 1, 1, "R12", 0, 1);

        // R1: disable in the middle of a frame
        @(negedge clk);
        div_i = 8'd2; start_i = 1;
        @(negedge clk);
        start_i = 0;
        repeat (10) @(negedge clk);
        cfg_enable = 0;
        @(negedge clk);
        chk(busy_o == 0, "R1", "abandoned on disable", busy_o, 0);
        chk(idle_o == 1, "R1", "idle on disable", idle_o, 1);
        repeat (60) @(negedge clk);
        cfg_enable = 1;
        xfer(8'h0F, 8'hF0, 0, 0, 0, 0, 0, 0, "R1");

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL R10 watchdog expired: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule